// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block sits beside the shifter of an SPI peripheral and decides when the pins show a mode fault. It runs on the system clock. It takes the raw slave-select and serial-clock pins through a synchronizer, and it takes the peripheral's control bits as plain levels. It does not shift data, generate a baud clock or decode register writes.

In the master role, with fault detection enabled, another device pulling slave-select low is a fault. That fault sets a sticky flag and fires four one-cycle strobes toward the rest of the peripheral:
- clear the enable bit,
- set the transmit-empty flag,
- clear the bit-state counter,
- hand the pin drivers back to port direction control.

In the slave role, a fault is slave-select rising while a transfer is under way. The block works out that framing itself, from clock phase and polarity, by counting the edges where the clock returns to its idle level. It also merges receive-full, overrun and the fault flag into one interrupt request.

The block never writes the master-select bit. Software can therefore read that bit after a fault to tell a master fault from a slave fault. All control and status pins are plain levels. There is no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `spi_mode_fault_det`

## Requirements
- R1: After reset, `fault_flag` is 0, all four strobes are 0, and `irq` is 0 while `rx_full` and `overrun` are 0.
- R2: With `spi_en`=1, `master_sel`=1 and `fault_en`=1, a falling edge on `ss_pin` sets `fault_flag`. The flag is visible three clock cycles after the pin changes: two synchronizer stages plus the flag register.
- R3: A master fault raises `clr_enable`, `set_tx_empty`, `clr_bitcnt` and `release_pins` together for exactly one cycle. That cycle is the same cycle in which `fault_flag` first reads 1.
- R4: While `fault_en`=0, `fault_flag` never sets, in either role.
- R5: In the slave role (`spi_en`=1, `master_sel`=0, `fault_en`=1), `ss_pin` rising during a transfer sets `fault_flag`.
- R6: With `cpha`=0, a slave transfer begins when `ss_pin` falls. Selecting and then deselecting the slave with no clock edge in between is a fault.
- R7: With `cpha`=0, the transfer ends when `sck_pin` returns to idle for the eighth time. Deselecting after that end is not a fault.
- R8: With `cpha`=1, a slave transfer begins only when `sck_pin` leaves idle while `ss_pin` is low, and it ends after the eighth return to idle. Deselecting before the first clock edge is not a fault, and neither is deselecting after the end. Deselecting mid-transfer is a fault.
- R9: `irq` = `rx_full` OR (`err_irq_en` AND (`fault_flag` OR `overrun`)). This is combinational and appears in the same cycle as its inputs.
- R10: A slave fault sets only `fault_flag`. The four strobes stay 0.
- R11: `fault_flag` stays set until `flag_clr` is high for one cycle, and it reads 0 in the following cycle. When a new fault and `flag_clr` arrive in the same cycle, the flag stays 1.
- R12: The idle level of `sck_pin` equals `cpol`. With `cpol`=1, a slave deselected after seven full bits and the eighth clock leaving idle (high to low) is a fault. After eight full bits it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_pin | input | 1 | Raw slave-select pin, active low |
| sck_pin | input | 1 | Raw serial-clock pin |
| spi_en | input | 1 | Peripheral enable |
| master_sel | input | 1 | 1 = master role, 0 = slave role |
| fault_en | input | 1 | Mode-fault detection enable |
| err_irq_en | input | 1 | Lets the fault and overrun flags reach `irq` |
| cpha | input | 1 | Clock phase |
| cpol | input | 1 | Clock polarity; idle level of SCK |
| rx_full | input | 1 | Receive-full flag |
| overrun | input | 1 | Overrun flag |
| flag_clr | input | 1 | One-cycle clear of the fault flag |
| fault_flag | output | 1 | Sticky mode-fault flag |
| clr_enable | output | 1 | One-cycle strobe to clear the enable bit |
| set_tx_empty | output | 1 | One-cycle strobe to set transmit-empty |
| clr_bitcnt | output | 1 | One-cycle strobe to clear the bit-state counter |
| release_pins | output | 1 | One-cycle strobe returning the pins to port control |
| irq | output | 1 | Combined receiver/error interrupt request |

## Verification
The bench builds the block with its defaults: `BITS`=8 and `SYNC_STAGES`=2. With these values the end of a transfer falls on the eighth return to idle, so the bench can deselect one clock edge before that point and one full bit after it. The two-stage synchronizer fixes the pin-to-flag latency at three cycles, and every expected flag and strobe value is timed from that figure. Both clock polarities are used in the slave role, so a detector that ignores `cpol` ends the transfer early and misses the fault that R12 expects.

// File: rtl/spimf_pkg.sv
package spimf_pkg;
  localparam int unsigned DEF_BITS        = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // SCK moves away from its idle level between two samples
  function automatic logic leaves_idle(input logic cur, input logic prev, input logic idle);
    return (prev == idle) && (cur != idle);
  endfunction

  // SCK comes back to its idle level between two samples
  function automatic logic back_to_idle(input logic cur, input logic prev, input logic idle);
    return (prev != idle) && (cur == idle);
  endfunction
endpackage

// File: rtl/spimf_sync.sv
module spimf_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= RST_VAL;
    else q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spimf_slave_frame.sv
module spimf_slave_frame
  import spimf_pkg::*;
#(
  parameter int unsigned BITS = DEF_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_on,
  input  logic cpha,
  input  logic cpol,
  input  logic ss,
  input  logic ss_prev,
  input  logic sck,
  input  logic sck_prev,
  output logic active
);
  localparam int unsigned CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt;
  logic ss_fall, lead, trail, start;

  assign ss_fall = !ss && ss_prev;
  assign lead    = leaves_idle(sck, sck_prev, cpol);
  assign trail   = back_to_idle(sck, sck_prev, cpol);
  // phase 0 opens on select, phase 1 on the first clock edge under select
  assign start   = cpha ? (!active && lead) : ss_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!slave_on || ss) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && trail) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: deselect always drops the frame
  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ss |=> !active);
  // R7: bit count stays below the transfer length
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R8: phase 1 frame opens on a clock edge under select
  a_r8_cpha1_open: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_on && cpha && !ss && !active && lead) |=> active);
endmodule

// File: rtl/spimf_flag.sv
module spimf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_master,
  input  logic set_slave,
  input  logic clr,
  output logic flag,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= set_master;
      if (set_master || set_slave) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R11: sticky without clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R11: clear without a new fault empties the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_master && !set_slave) |=> !flag);
  // R11: a new fault wins over a clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_master || set_slave) |=> flag);
  // R3: strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !set_master) |=> !pulse);
  // R10: slave fault gives no strobe
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (set_slave && !set_master) |=> !pulse);
endmodule

// File: rtl/spi_mode_fault_det.sv
module spi_mode_fault_det
  import spimf_pkg::*;
#(
  parameter int unsigned BITS        = DEF_BITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_pin,
  input  logic sck_pin,
  input  logic spi_en,
  input  logic master_sel,
  input  logic fault_en,
  input  logic err_irq_en,
  input  logic cpha,
  input  logic cpol,
  input  logic rx_full,
  input  logic overrun,
  input  logic flag_clr,
  output logic fault_flag,
  output logic clr_enable,
  output logic set_tx_empty,
  output logic clr_bitcnt,
  output logic release_pins,
  output logic irq
);
  logic ss_s, ss_p, sck_s, sck_p;
  logic slave_on, frame_active;
  logic fault_m, fault_s, pulse;

  spimf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .din(ss_pin), .q(ss_s), .q_prev(ss_p));

  spimf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sck_pin), .q(sck_s), .q_prev(sck_p));

  assign slave_on = spi_en && !master_sel;

  spimf_slave_frame #(.BITS(BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .slave_on(slave_on), .cpha(cpha), .cpol(cpol),
    .ss(ss_s), .ss_prev(ss_p), .sck(sck_s), .sck_prev(sck_p),
    .active(frame_active));

  // master: select driven low by someone else; slave: deselect mid-frame
  assign fault_m = fault_en && spi_en && master_sel && !ss_s && ss_p;
  assign fault_s = fault_en && slave_on && ss_s && !ss_p && frame_active;

  spimf_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_master(fault_m), .set_slave(fault_s),
    .clr(flag_clr), .flag(fault_flag), .pulse(pulse));

  assign clr_enable   = pulse;
  assign set_tx_empty = pulse;
  assign clr_bitcnt   = pulse;
  assign release_pins = pulse;

  assign irq = rx_full || (err_irq_en && (fault_flag || overrun));

  // R4: no detection, no new flag
  a_r4_disabled_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_en && !fault_flag) |=> !fault_flag);
  // R2: master select loss sets flag and strobe
  a_r2_master_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && master_sel && fault_en && !ss_s && ss_p) |=> (fault_flag && clr_enable));
  // R3: strobes only alongside a set flag
  a_r3_strobe_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clr_enable |-> fault_flag);
endmodule

// File: tb/sim_spi_mode_fault_det.sv
module sim_spi_mode_fault_det;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n, ss_pin, sck_pin, spi_en, master_sel, fault_en, err_irq_en;
  logic cpha, cpol, rx_full, overrun, flag_clr;
  logic fault_flag, clr_enable, set_tx_empty, clr_bitcnt, release_pins, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mode_fault_det u0 (
    .clk(clk), .rst_n(rst_n), .ss_pin(ss_pin), .sck_pin(sck_pin),
    .spi_en(spi_en), .master_sel(master_sel), .fault_en(fault_en),
    .err_irq_en(err_irq_en), .cpha(cpha), .cpol(cpol), .rx_full(rx_full),
    .overrun(overrun), .flag_clr(flag_clr), .fault_flag(fault_flag),
    .clr_enable(clr_enable), .set_tx_empty(set_tx_empty), .clr_bitcnt(clr_bitcnt),
    .release_pins(release_pins), .irq(irq));

  typedef struct {
    int    due;
    bit    cf; bit f;
    bit    cs; bit s;
    bit    ci; bit i;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expectations as their cycle arrives
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      if (e.cf) begin
        checks++;
        if (fault_flag !== e.f) begin
          fails++;
          $display("FAIL %s fault_flag actual=%b expected=%b cyc=%0d", e.tag, fault_flag, e.f, cyc);
        end
      end
      if (e.cs) begin
        checks++;
        if ({clr_enable, set_tx_empty, clr_bitcnt, release_pins} !== {4{e.s}}) begin
          fails++;
          $display("FAIL %s strobes actual=%b%b%b%b expected=%b x4 cyc=%0d", e.tag,
                   clr_enable, set_tx_empty, clr_bitcnt, release_pins, e.s, cyc);
        end
      end
      if (e.ci) begin
        checks++;
        if (irq !== e.i) begin
          fails++;
          $display("FAIL %s irq actual=%b expected=%b cyc=%0d", e.tag, irq, e.i, cyc);
        end
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int d, input bit cf, input bit f, input bit cs, input bit s,
                      input bit ci, input bit i, input string tag);
    exp_t e;
    e.due = cyc + d; e.cf = cf; e.f = f; e.cs = cs; e.s = s; e.ci = ci; e.i = i; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expf(input int d, input bit f, input string tag);
    push(d, 1, f, 0, 0, 0, 0, tag);
  endtask

  task automatic clear_flag(input string tag);
    flag_clr = 1'b1;
    expf(1, 0, tag);
    wt(1);
    flag_clr = 1'b0;
    wt(2);
  endtask

  task automatic bits(input int n);
    for (int k = 0; k < n; k++) begin
      sck_pin = ~cpol; wt(3);
      sck_pin = cpol;  wt(3);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ss_pin = 1; sck_pin = 0; spi_en = 0; master_sel = 0; fault_en = 0;
    err_irq_en = 0; cpha = 0; cpol = 0; rx_full = 0; overrun = 0; flag_clr = 0;
    wt(3);
    rst_n = 1;
    wt(1);
    push(0, 1, 0, 1, 0, 1, 0, "R1 reset");
    wt(1);

    // R9 interrupt merge
    rx_full = 1; push(0, 0, 0, 0, 0, 1, 1, "R9 rx_full");
    wt(1);
    rx_full = 0; overrun = 1; push(0, 0, 0, 0, 0, 1, 0, "R9 overrun masked");
    wt(1);
    err_irq_en = 1; push(0, 0, 0, 0, 0, 1, 1, "R9 overrun enabled");
    wt(1);
    overrun = 0; err_irq_en = 0; push(0, 0, 0, 0, 0, 1, 0, "R9 idle");
    wt(1);

    // R4 master with detection off
    spi_en = 1; master_sel = 1; fault_en = 0;
    wt(2);
    ss_pin = 0;
    push(3, 1, 0, 1, 0, 0, 0, "R4 master");
    expf(6, 0, "R4 master later");
    wt(8); ss_pin = 1; wt(5);

    // R2 / R3 master fault
    fault_en = 1; err_irq_en = 1;
    ss_pin = 0;
    push(3, 1, 1, 1, 1, 0, 0, "R2 R3 master fault");
    push(4, 1, 1, 1, 0, 1, 1, "R3 strobe ends / R9 flag irq");
    wt(6); ss_pin = 1; wt(4);

    // R11 sticky, clear, set wins
    expf(0, 1, "R11 sticky");
    wt(10);
    expf(0, 1, "R11 sticky later");
    clear_flag("R11 clear");
    ss_pin = 0;
    wt(2);
    flag_clr = 1;
    expf(1, 1, "R11 set wins");
    wt(1); flag_clr = 0; wt(3);
    ss_pin = 1; wt(4);
    clear_flag("R11 clear again");
    err_irq_en = 0;

    // slave role, phase 0, polarity 0
    master_sel = 0; cpha = 0; cpol = 0; sck_pin = 0;
    fault_en = 0;
    wt(3);
    ss_pin = 0; wt(5); ss_pin = 1;
    expf(3, 0, "R4 slave");
    wt(6);

    fault_en = 1;
    ss_pin = 0; wt(5); ss_pin = 1;
    push(3, 1, 1, 1, 0, 1, 0, "R6 R10 select-deselect");
    wt(6);
    clear_flag("R6 clear");

    ss_pin = 0; wt(4); bits(8); wt(2); ss_pin = 1;
    expf(3, 0, "R7 full byte");
    expf(5, 0, "R7 full byte later");
    wt(6);

    ss_pin = 0; wt(4); bits(3); ss_pin = 1;
    expf(3, 1, "R5 mid transfer");
    wt(6);
    clear_flag("R5 clear");

    // R12 polarity 1
    sck_pin = 1; cpol = 1; wt(5);
    ss_pin = 0; wt(4); bits(7); sck_pin = 0; wt(4); ss_pin = 1;
    expf(3, 1, "R12 eighth clock not idle");
    wt(6);
    sck_pin = 1; wt(4);
    clear_flag("R12 clear");
    ss_pin = 0; wt(4); bits(8); wt(2); ss_pin = 1;
    expf(3, 0, "R12 full byte cpol1");
    wt(6);
    sck_pin = 0; cpol = 0; wt(5);

    // R8 phase 1
    cpha = 1; wt(3);
    ss_pin = 0; wt(5); ss_pin = 1;
    expf(3, 0, "R8 no clock no frame");
    wt(6);
    ss_pin = 0; wt(4); bits(4); ss_pin = 1;
    expf(3, 1, "R8 mid transfer");
    wt(6);
    clear_flag("R8 clear");
    ss_pin = 0; wt(4); bits(8); wt(2); ss_pin = 1;
    expf(3, 0, "R8 full byte");
    wt(8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule